// File: doc/BRIEF.md
# Registered Two-Port Bus Transceiver

This block joins two bidirectional buses, port A and port B, each `WIDTH` bits wide. Each direction has its own storage register, loaded when that direction's capture input rises. A select per direction chooses what the far port drives: the live value from the opposite bus, or the stored register contents. The driver toward B is enabled by an active-high input. The driver toward A is enabled by an active-low input. When both selects are live and both drivers are on, each bus holds its own value from the previous system-clock cycle, so the bus keeps its state without the storage registers.

The pins are modelled as split signals. Each port has an external input value, a driven value, an output enable and a resolved value. The storage registers and the live paths always work on the resolved value. The capture inputs are sampled in the system-clock domain. A capture happens at the first `clk` edge that sees the capture input high after it was low. It happens whatever the enables and selects are doing.

Top module: `regBusXcvr`

## Requirements
- R1: An active-low asynchronous reset clears both storage registers and both hold registers to zero. After reset, a stored transfer drives 0 on the enabled port.
- R2: The A-side register loads the resolved A value when `capAB` rises. This happens for every setting of the enables and selects.
- R3: The B-side register loads the resolved B value when `capBA` rises. This happens for every setting of the enables and selects.
- R4: `bBusOe` equals `drvBEn` (1 = B driven). While B is not driven, `bBusOut` is 0.
- R5: `aBusOe` equals the inverse of `drvAEnN` (0 = A driven). While A is not driven, `aBusOut` is 0.
- R6: While B is driven outside hold mode, B carries the resolved A value when `selAB`=0 and the A-side register when `selAB`=1.
- R7: While A is driven outside hold mode, A carries the resolved B value when `selBA`=0 and the B-side register when `selBA`=1.
- R8: A port's resolved value equals its driven value while its driver is enabled. Otherwise it equals the external input of that port.
- R9: Hold mode is `drvBEn`=1, `drvAEnN`=0, `selAB`=0 and `selBA`=0. In this mode each resolved bus value equals its own value from the previous `clk` cycle, and the external inputs have no effect.
- R10: A capture input held high loads its register only once, on the cycle it rises. Later data does not replace the stored value until the input falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| capAB | input | 1 | Capture request for the A-side register (rising) |
| capBA | input | 1 | Capture request for the B-side register (rising) |
| drvBEn | input | 1 | Drive B port, active high |
| drvAEnN | input | 1 | Drive A port, active low |
| selAB | input | 1 | B source: 0 live A, 1 A-side register |
| selBA | input | 1 | A source: 0 live B, 1 B-side register |
| aBusIn | input | WIDTH | External value on bus A |
| aBusOut | output | WIDTH | Value driven onto bus A |
| aBusOe | output | 1 | A driver enable |
| aBusVal | output | WIDTH | Resolved bus A value |
| bBusIn | input | WIDTH | External value on bus B |
| bBusOut | output | WIDTH | Value driven onto bus B |
| bBusOe | output | 1 | B driver enable |
| bBusVal | output | WIDTH | Resolved bus B value |

## Verification
The bench builds the block with the default `WIDTH` of 8. The six control inputs (two enables, two selects, two capture inputs) then form only 64 combinations. The bench sweeps all of them in several rounds, each round with different data, so every operating mode is entered from many different register and hold states. Directed runs add the post-reset stored transfer, a long capture pulse, and hold mode entered after a live transfer.

// File: rtl/regBusXcvrPkg.sv
package regBusXcvrPkg;
  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic captureAB;  // load A-side register this cycle
    logic captureBA;  // load B-side register this cycle
    logic driveA;     // A driver on
    logic driveB;     // B driver on
    logic storedToB;  // B source is the A-side register
    logic storedToA;  // A source is the B-side register
    logic loopHold;   // both live paths and both drivers on
  } xcvrStrobes_t;
endpackage

// File: rtl/regBusXcvrCtrl.sv
module regBusXcvrCtrl
  import regBusXcvrPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         capAB,
  input  logic         capBA,
  input  logic         drvBEn,
  input  logic         drvAEnN,
  input  logic         selAB,
  input  logic         selBA,
  output xcvrStrobes_t strobes
);
  logic capABPrev;
  logic capBAPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capABPrev <= 1'b0;
      capBAPrev <= 1'b0;
    end else begin
      capABPrev <= capAB;
      capBAPrev <= capBA;
    end
  end

  always_comb begin
    strobes.captureAB = capAB & ~capABPrev;
    strobes.captureBA = capBA & ~capBAPrev;
    strobes.driveA    = ~drvAEnN;
    strobes.driveB    = drvBEn;
    strobes.storedToB = selAB;
    strobes.storedToA = selBA;
    strobes.loopHold  = ~drvAEnN & drvBEn & ~selAB & ~selBA;
  end
endmodule

// File: rtl/regBusXcvrData.sv
module regBusXcvrData
  import regBusXcvrPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  xcvrStrobes_t     strobes,
  input  logic [WIDTH-1:0] aBusIn,
  input  logic [WIDTH-1:0] bBusIn,
  output logic [WIDTH-1:0] aBusOut,
  output logic [WIDTH-1:0] bBusOut,
  output logic [WIDTH-1:0] aBusVal,
  output logic [WIDTH-1:0] bBusVal
);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] regAB;
  logic [WIDTH-1:0] regBA;
  logic [WIDTH-1:0] holdA;
  logic [WIDTH-1:0] holdB;

  // Resolved values in closed form. Outside hold mode, a live path whose far
  // side is driven must be fed from that side's register, so neither
  // expression refers to the other and no combinational loop is formed.
  always_comb begin
    if (!strobes.driveA)         aBusVal = aBusIn;
    else if (strobes.loopHold)   aBusVal = holdA;
    else if (strobes.storedToA)  aBusVal = regBA;
    else if (strobes.driveB)     aBusVal = regAB;
    else                         aBusVal = bBusIn;

    if (!strobes.driveB)         bBusVal = bBusIn;
    else if (strobes.loopHold)   bBusVal = holdB;
    else if (strobes.storedToB)  bBusVal = regAB;
    else if (strobes.driveA)     bBusVal = regBA;
    else                         bBusVal = aBusIn;

    aBusOut = strobes.driveA ? aBusVal : ZERO;
    bBusOut = strobes.driveB ? bBusVal : ZERO;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regAB <= ZERO;
      regBA <= ZERO;
      holdA <= ZERO;
      holdB <= ZERO;
    end else begin
      if (strobes.captureAB) regAB <= aBusVal;
      if (strobes.captureBA) regBA <= bBusVal;
      holdA <= aBusVal;
      holdB <= bBusVal;
    end
  end
endmodule

// File: rtl/regBusXcvr.sv
module regBusXcvr
  import regBusXcvrPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capAB,
  input  logic             capBA,
  input  logic             drvBEn,
  input  logic             drvAEnN,
  input  logic             selAB,
  input  logic             selBA,
  input  logic [WIDTH-1:0] aBusIn,
  output logic [WIDTH-1:0] aBusOut,
  output logic             aBusOe,
  output logic [WIDTH-1:0] aBusVal,
  input  logic [WIDTH-1:0] bBusIn,
  output logic [WIDTH-1:0] bBusOut,
  output logic             bBusOe,
  output logic [WIDTH-1:0] bBusVal
);
  xcvrStrobes_t strobes;

  regBusXcvrCtrl ctrlInst (
    .clk(clk), .rstN(rstN), .capAB(capAB), .capBA(capBA),
    .drvBEn(drvBEn), .drvAEnN(drvAEnN), .selAB(selAB), .selBA(selBA),
    .strobes(strobes)
  );

  regBusXcvrData #(.WIDTH(WIDTH)) dataInst (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .aBusIn(aBusIn), .bBusIn(bBusIn),
    .aBusOut(aBusOut), .bBusOut(bBusOut),
    .aBusVal(aBusVal), .bBusVal(bBusVal)
  );

  assign aBusOe = strobes.driveA;
  assign bBusOe = strobes.driveB;
endmodule

// File: rtl/regBusXcvrChk.sv
module regBusXcvrChk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             capAB,
  input logic             drvBEn,
  input logic             drvAEnN,
  input logic             selAB,
  input logic             selBA,
  input logic [WIDTH-1:0] aBusIn,
  input logic [WIDTH-1:0] aBusVal,
  input logic             aBusOe,
  input logic [WIDTH-1:0] bBusIn,
  input logic [WIDTH-1:0] bBusVal,
  input logic [WIDTH-1:0] bBusOut,
  input logic             bBusOe
);
  logic holdMode;
  assign holdMode = drvBEn && !drvAEnN && !selAB && !selBA;

  // R8
  undriven_a_follows_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    !aBusOe |-> aBusVal == aBusIn);

  // R8
  undriven_b_follows_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bBusOe |-> bBusVal == bBusIn);

  // R4
  quiet_b_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    !drvBEn |-> bBusOut == '0);

  // R6
  live_a_to_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (drvBEn && !selAB && !holdMode) |-> bBusVal == aBusVal);

  // R9
  hold_keeps_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdMode && $past(holdMode)) |-> aBusVal == $past(aBusVal));

  // R2
  capture_then_stored_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(capAB) && !$past(capAB, 2) && selAB && drvBEn) |-> bBusVal == $past(aBusVal));
endmodule

bind regBusXcvr regBusXcvrChk #(.WIDTH(WIDTH)) chkInst (
  .clk(clk), .rstN(rstN), .capAB(capAB), .drvBEn(drvBEn), .drvAEnN(drvAEnN),
  .selAB(selAB), .selBA(selBA), .aBusIn(aBusIn), .aBusVal(aBusVal),
  .aBusOe(aBusOe), .bBusIn(bBusIn), .bBusVal(bBusVal), .bBusOut(bBusOut),
  .bBusOe(bBusOe)
);

// File: tb/regBusXcvr_test.sv
module regBusXcvr_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic capAB = 0, capBA = 0, drvBEn = 0, drvAEnN = 1, selAB = 0, selBA = 0;
  logic [W-1:0] aBusIn = '0, bBusIn = '0;
  logic [W-1:0] aBusOut, aBusVal, bBusOut, bBusVal;
  logic aBusOe, bBusOe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] mRegAB, mRegBA, mHoldA, mHoldB;
  logic mPrevAB, mPrevBA;

  always #4 clk = ~clk;

  regBusXcvr #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .capAB(capAB), .capBA(capBA),
    .drvBEn(drvBEn), .drvAEnN(drvAEnN), .selAB(selAB), .selBA(selBA),
    .aBusIn(aBusIn), .aBusOut(aBusOut), .aBusOe(aBusOe), .aBusVal(aBusVal),
    .bBusIn(bBusIn), .bBusOut(bBusOut), .bBusOe(bBusOe), .bBusVal(bBusVal)
  );

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // One cycle: apply at negedge, check settled outputs, then advance the model
  task automatic step(input bit oeB, input bit oeAN, input bit sAB, input bit sBA,
                      input bit cAB, input bit cBA, input logic [W-1:0] ai,
                      input logic [W-1:0] bi, input string tag);
    logic [W-1:0] expA, expB;
    bit dA, dB, loopM;
    drvBEn = oeB; drvAEnN = oeAN; selAB = sAB; selBA = sBA;
    capAB = cAB; capBA = cBA; aBusIn = ai; bBusIn = bi;
    #1;
    dA = !oeAN; dB = oeB; loopM = dA && dB && !sAB && !sBA;
    // R8: undriven port shows its input; R9: hold mode shows own previous value
    if (!dA)       expA = ai;
    else if (loopM) expA = mHoldA;
    else if (sBA)  expA = mRegBA;        // R7 stored
    else           expA = dB ? mRegAB : bi; // R7 live B (B then carries stored A)
    if (!dB)       expB = bi;
    else if (loopM) expB = mHoldB;
    else if (sAB)  expB = mRegAB;        // R6 stored
    else           expB = dA ? mRegBA : ai; // R6 live A
    check({tag, " R5"}, "aBusOe", aBusOe, dA);
    check({tag, " R4"}, "bBusOe", bBusOe, dB);
    check({tag, " R7 R8 R9"}, "aBusVal", aBusVal, expA);
    check({tag, " R6 R8 R9"}, "bBusVal", bBusVal, expB);
    check({tag, " R5"}, "aBusOut", aBusOut, dA ? expA : 0);
    check({tag, " R4"}, "bBusOut", bBusOut, dB ? expB : 0);
    @(posedge clk);
    // R2 R3 R10: load on rising capture input only
    if (cAB && !mPrevAB) mRegAB = expA;
    if (cBA && !mPrevBA) mRegBA = expB;
    mPrevAB = cAB; mPrevBA = cBA;
    mHoldA = expA; mHoldB = expB;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mRegAB = '0; mRegBA = '0; mHoldA = '0; mHoldB = '0; mPrevAB = 0; mPrevBA = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: stored transfers both ways right after reset show zero
    step(1, 0, 1, 1, 0, 0, 8'hA5, 8'h3C, "R1");
    check("R1", "bBusVal after reset", bBusVal, 0);

    // R2 R10: capture A while isolated, keep capAB high while data changes
    step(0, 1, 0, 0, 1, 0, 8'h11, 8'h22, "R2 R10");
    step(0, 1, 0, 0, 1, 0, 8'h77, 8'h22, "R10");
    step(0, 1, 0, 0, 1, 0, 8'h99, 8'h22, "R10");
    step(1, 1, 1, 0, 0, 0, 8'h00, 8'h00, "R2 R10");
    check("R10", "stored A after long pulse", bBusVal, 8'h11);

    // R3: capture B while A drives stored data, then show it on A
    step(0, 0, 0, 1, 0, 1, 8'h00, 8'h6E, "R3");
    step(0, 0, 0, 1, 0, 0, 8'h00, 8'h00, "R3");
    check("R3", "stored B on A", aBusVal, 8'h6E);

    // R2 R3: live A to B with both captures stores A in both registers
    step(1, 1, 0, 0, 1, 1, 8'hC3, 8'h00, "R2 R3");
    step(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R2 R3");
    check("R3", "A stored in B-side register", aBusVal, 8'hC3);

    // R9: enter hold from a live transfer, inputs then ignored
    step(1, 1, 0, 0, 0, 0, 8'h5A, 8'hFF, "R9");
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 0, 0, 0, 0, 8'h0F ^ 8'(i), 8'hF0 + 8'(i), "R9");
      check("R9", "held A", aBusVal, 8'h5A);
      check("R9", "held B", bBusVal, 8'h5A);
    end

    // Sweep all 64 control combinations with varied data
    for (int r = 0; r < 6; r++) begin
      for (int c = 0; c < 64; c++) begin
        step(c[0], c[1], c[2], c[3], c[4], c[5],
             8'((r * 37 + c * 13) ^ 8'h5C), 8'((r * 91 + c * 29) ^ 8'hA3),
             "sweep R2 R3 R10");
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule